// File: doc/BRIEF.md
# RTC Register Access Guard

This block sits between a simple register bus and the calendar core of a real-time clock. It holds the time, date, prescaler, control and alarm registers and refuses every write to them until a two-value key has been written to a dedicated key register. Any further key write closes access again. Software therefore opens the block, performs a short update and closes it, and a stray write outside that window changes nothing.

The calendar runs on a slow RTC clock, while the bus runs on a fast clock. To load time, date or prescaler, software sets an init request bit. The request crosses into the RTC domain through a two-flop synchroniser and holds the calendar. The acknowledge returns through a second synchroniser and appears as a status flag. Time, date and prescaler only accept writes while both the request and the acknowledge are set. A shadow-sync flag can be cleared by software. The hardware sets it again after a round trip through the RTC domain, which tells software that the calendar copies are fresh. A separate flag reports whether a nonzero year has been loaded.

Top module: `rtc_access_guard`

## Requirements
- R1: After reset, TIME, DATE, CTRL and ALARM read 0 and PRESC reads 0x7F00FF. STAT reads 0x20, meaning only the sync flag (bit 5) is set. The key register (word 7) always reads 0, and cal_hold is 0.
- R2: Access opens after 0xCA and then 0x53 are written to the low 8 bits of the key register (word 7) on two consecutive key writes. Writes to other registers in between do not break the sequence.
- R3: Any key write while access is open closes it. A second key value other than 0x53 returns the sequence to its closed start, so a following 0x53 does not open access.
- R4: While access is closed, writes are ignored and leave register contents unchanged. This covers CTRL (word 2, 16 bits), ALARM (word 5, 32 bits) and STAT (word 3). A closed STAT write neither raises the init request nor clears the sync flag.
- R5: TIME (word 0, 22 bits), DATE (word 1, 24 bits) and PRESC (word 4, 23 bits) accept a write only while access is open and both STAT bit 7 (init request) and STAT bit 6 (init acknowledge) are 1. Data bits above each field width are dropped.
- R6: Writing STAT bit 7 = 1 while access is open raises cal_hold after two RTC clock edges. The acknowledge in STAT bit 6 then follows two bus clock edges later, so it is still 0 on the first read after the write and is 1 within 20 bus cycles.
- R7: Writing STAT bit 7 = 0 releases cal_hold and clears STAT bit 6 through the same two synchroniser paths. After this, TIME writes are ignored.
- R8: Writing STAT with bit 5 = 0 while access is open clears the sync flag at once. The flag returns to 1 by itself within 20 bus cycles, after a round trip through two RTC flops and two bus flops. Writing bit 5 = 1 has no effect on the flag.
- R9: STAT bit 4 reads 1 exactly when the year field DATE[23:16] is nonzero.
- R10: bus_rdata shows the register selected by bus_addr one bus clock later, zero-extended. cal_time, cal_date, cal_presc, cal_ctrl and cal_alarm mirror the stored registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| rtc_clk | input | 1 | Slow RTC clock |
| rtc_rst | input | 1 | Synchronous active-high reset, RTC domain |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| cal_hold | output | 1 | Calendar hold, RTC domain |
| cal_time | output | TIME_W | Stored time value |
| cal_date | output | DATE_W | Stored date value |
| cal_presc | output | PRESC_W | Stored prescaler value |
| cal_ctrl | output | CTRL_W | Stored control value |
| cal_alarm | output | DATA_W | Stored alarm value |

## Verification
The bench checks the key sequence at its edges. It tries a wrong second key followed by the right one, and a relock through an arbitrary key value. A lock machine that only looked for 0x53, or that stayed open after a second write, would let a CTRL write land. It also writes time while access is open but before the acknowledge. A guard that checked only the lock state would accept that value. Finally, it measures the init acknowledge and the sync-flag return against the synchroniser round trip. A crossing that skipped a stage would show the acknowledge on the first read. A flag that never re-armed would leave the sync bit at 0 and time out.

// File: rtl/rtcfe_pkg.sv
`timescale 1ns/1ps
package rtcfe_pkg;

  typedef enum logic [1:0] {
    KL_SHUT = 2'd0,
    KL_HALF = 2'd1,
    KL_OPEN = 2'd2
  } key_state_e;

  // word indexes of the register map
  localparam int A_TIME  = 0;
  localparam int A_DATE  = 1;
  localparam int A_CTRL  = 2;
  localparam int A_STAT  = 3;
  localparam int A_PRESC = 4;
  localparam int A_ALARM = 5;
  localparam int A_KEY   = 7;

  // status bit positions decoded by software
  localparam int ST_INITREQ = 7;
  localparam int ST_INITACK = 6;
  localparam int ST_SYNCED  = 5;
  localparam int ST_LOADED  = 4;

endpackage

// File: rtl/rtcfe_sync_chain.sv
`timescale 1ns/1ps
module rtcfe_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rtcfe_key_lock.sv
`timescale 1ns/1ps
module rtcfe_key_lock
  import rtcfe_pkg::*;
#(
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] FIRST_KEY  = 8'hCA,
  parameter logic [KEY_W-1:0] SECOND_KEY = 8'h53
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_val,
  output logic             open
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_we) begin
      case (st_q)
        KL_SHUT: st_d = (key_val == FIRST_KEY)  ? KL_HALF : KL_SHUT;
        KL_HALF: st_d = (key_val == SECOND_KEY) ? KL_OPEN : KL_SHUT;
        default: st_d = KL_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KL_SHUT;
      open <= 1'b0;
    end else begin
      st_q <= st_d;
      open <= (st_d == KL_OPEN);
    end
  end

  assert_open_after_second_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(open) |-> ($past(key_we) && $past(key_val) == SECOND_KEY));

  assert_relock_on_key_R3: assert property (@(posedge clk) disable iff (rst)
    (open && key_we) |=> !open);
endmodule

// File: rtl/rtcfe_cdc_bridge.sv
`timescale 1ns/1ps
module rtcfe_cdc_bridge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rtc_clk,
  input  logic rtc_rst,
  input  logic init_req,
  input  logic sync_tgl,
  output logic init_ack,
  output logic sync_ack,
  output logic cal_hold
);
  logic sync_tgl_rtc;

  // bus -> rtc: init request becomes the calendar hold
  rtcfe_sync_chain #(.STAGES(STAGES)) u_req_fwd (
    .clk(rtc_clk), .rst(rtc_rst), .d(init_req), .q(cal_hold));

  // rtc -> bus: hold level returns as the acknowledge
  rtcfe_sync_chain #(.STAGES(STAGES)) u_req_back (
    .clk(clk), .rst(rst), .d(cal_hold), .q(init_ack));

  // bus -> rtc: shadow refresh request toggle
  rtcfe_sync_chain #(.STAGES(STAGES)) u_tgl_fwd (
    .clk(rtc_clk), .rst(rtc_rst), .d(sync_tgl), .q(sync_tgl_rtc));

  // rtc -> bus: refresh done toggle
  rtcfe_sync_chain #(.STAGES(STAGES)) u_tgl_back (
    .clk(clk), .rst(rst), .d(sync_tgl_rtc), .q(sync_ack));
endmodule

// File: rtl/rtc_access_guard.sv
`timescale 1ns/1ps
module rtc_access_guard
  import rtcfe_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32,
  parameter int TIME_W   = 22,
  parameter int DATE_W   = 24,
  parameter int PRESC_W  = 23,
  parameter int CTRL_W   = 16,
  parameter int KEY_W    = 8,
  parameter int YEAR_LSB = 16,
  parameter int YEAR_W   = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [KEY_W-1:0]   FIRST_KEY  = 8'hCA,
  parameter logic [KEY_W-1:0]   SECOND_KEY = 8'h53,
  parameter logic [PRESC_W-1:0] PRESC_RST  = 23'h7F00FF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rtc_clk,
  input  logic               rtc_rst,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               cal_hold,
  output logic [TIME_W-1:0]  cal_time,
  output logic [DATE_W-1:0]  cal_date,
  output logic [PRESC_W-1:0] cal_presc,
  output logic [CTRL_W-1:0]  cal_ctrl,
  output logic [DATA_W-1:0]  cal_alarm
);
  localparam logic [ADDR_W-1:0] AD_TIME  = ADDR_W'(A_TIME);
  localparam logic [ADDR_W-1:0] AD_DATE  = ADDR_W'(A_DATE);
  localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_STAT  = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] AD_PRESC = ADDR_W'(A_PRESC);
  localparam logic [ADDR_W-1:0] AD_ALARM = ADDR_W'(A_ALARM);
  localparam logic [ADDR_W-1:0] AD_KEY   = ADDR_W'(A_KEY);

  logic [TIME_W-1:0]  time_q;
  logic [DATE_W-1:0]  date_q;
  logic [PRESC_W-1:0] presc_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  alarm_q;
  logic               init_req_q;
  logic               synced_q;
  logic               sync_tgl_q;
  logic               open;
  logic               init_ack;
  logic               sync_ack;
  logic               sync_busy;
  logic               load_ok;
  logic               loaded;
  logic [DATA_W-1:0]  stat_word;

  rtcfe_key_lock #(
    .KEY_W(KEY_W), .FIRST_KEY(FIRST_KEY), .SECOND_KEY(SECOND_KEY)
  ) u_lock (
    .clk     (clk),
    .rst     (rst),
    .key_we  (bus_we && bus_addr == AD_KEY),
    .key_val (bus_wdata[KEY_W-1:0]),
    .open    (open)
  );

  rtcfe_cdc_bridge #(.STAGES(SYNC_STAGES)) u_bridge (
    .clk      (clk),
    .rst      (rst),
    .rtc_clk  (rtc_clk),
    .rtc_rst  (rtc_rst),
    .init_req (init_req_q),
    .sync_tgl (sync_tgl_q),
    .init_ack (init_ack),
    .sync_ack (sync_ack),
    .cal_hold (cal_hold)
  );

  assign load_ok   = open && init_req_q && init_ack;
  assign sync_busy = (sync_tgl_q != sync_ack);
  assign loaded    = |date_q[YEAR_LSB +: YEAR_W];

  // protected register file
  always_ff @(posedge clk) begin
    if (rst) begin
      time_q     <= '0;
      date_q     <= '0;
      presc_q    <= PRESC_RST;
      ctrl_q     <= '0;
      alarm_q    <= '0;
      init_req_q <= 1'b0;
    end else if (bus_we && open) begin
      if (bus_addr == AD_CTRL)  ctrl_q     <= bus_wdata[CTRL_W-1:0];
      if (bus_addr == AD_ALARM) alarm_q    <= bus_wdata;
      if (bus_addr == AD_STAT)  init_req_q <= bus_wdata[ST_INITREQ];
      if (load_ok) begin
        if (bus_addr == AD_TIME)  time_q  <= bus_wdata[TIME_W-1:0];
        if (bus_addr == AD_DATE)  date_q  <= bus_wdata[DATE_W-1:0];
        if (bus_addr == AD_PRESC) presc_q <= bus_wdata[PRESC_W-1:0];
      end
    end
  end

  // shadow sync flag: cleared by software, re-armed after the round trip
  always_ff @(posedge clk) begin
    if (rst) begin
      synced_q   <= 1'b1;
      sync_tgl_q <= 1'b0;
    end else if (bus_we && open && bus_addr == AD_STAT &&
                 !bus_wdata[ST_SYNCED] && !sync_busy) begin
      synced_q   <= 1'b0;
      sync_tgl_q <= ~sync_tgl_q;
    end else if (!synced_q && !sync_busy) begin
      synced_q <= 1'b1;
    end
  end

  always_comb begin
    stat_word             = '0;
    stat_word[ST_INITREQ] = init_req_q;
    stat_word[ST_INITACK] = init_ack;
    stat_word[ST_SYNCED]  = synced_q;
    stat_word[ST_LOADED]  = loaded;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        AD_TIME:  bus_rdata <= DATA_W'(time_q);
        AD_DATE:  bus_rdata <= DATA_W'(date_q);
        AD_CTRL:  bus_rdata <= DATA_W'(ctrl_q);
        AD_STAT:  bus_rdata <= stat_word;
        AD_PRESC: bus_rdata <= DATA_W'(presc_q);
        AD_ALARM: bus_rdata <= alarm_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign cal_time  = time_q;
  assign cal_date  = date_q;
  assign cal_presc = presc_q;
  assign cal_ctrl  = ctrl_q;
  assign cal_alarm = alarm_q;

  assert_locked_ctrl_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!open && bus_we && bus_addr == AD_CTRL) |=> $stable(ctrl_q));

  assert_time_write_gated_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(time_q) |-> $past(bus_we && bus_addr == AD_TIME && open && init_req_q && init_ack));

  assert_sync_fall_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(synced_q) |-> $past(bus_we && bus_addr == AD_STAT && open));
endmodule

// File: tb/rtc_access_guard_test.sv
`timescale 1ns/1ps
module rtc_access_guard_test;
  logic        clk = 1'b0;
  logic        rtc_clk = 1'b0;
  logic        rst = 1'b1;
  logic        rtc_rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cal_hold;
  logic [21:0] cal_time;
  logic [23:0] cal_date;
  logic [22:0] cal_presc;
  logic [15:0] cal_ctrl;
  logic [31:0] cal_alarm;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;        // 50 MHz bus clock
  always #50 rtc_clk = ~rtc_clk; // slow RTC clock

  rtc_access_guard uut (
    .clk(clk), .rst(rst), .rtc_clk(rtc_clk), .rtc_rst(rtc_rst),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cal_hold(cal_hold), .cal_time(cal_time),
    .cal_date(cal_date), .cal_presc(cal_presc), .cal_ctrl(cal_ctrl),
    .cal_alarm(cal_alarm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // polls STAT until the bit takes the value; returns reads used (99 = never)
  task automatic poll_stat(input int bitpos, input logic val, output int used);
    logic [31:0] v;
    used = 99;
    for (int i = 1; i <= 40; i++) begin
      rd(3'd3, v);
      if (v[bitpos] === val) begin
        used = i;
        break;
      end
    end
  endtask

  task automatic unlock();
    wr(3'd7, 32'hCA);
    wr(3'd7, 32'h53);
  endtask

  task automatic t_reset();
    rd_check("R1 time", 3'd0, 32'h0);
    rd_check("R1 date", 3'd1, 32'h0);
    rd_check("R1 ctrl", 3'd2, 32'h0);
    rd_check("R1 stat", 3'd3, 32'h20);
    rd_check("R1 presc", 3'd4, 32'h7F00FF);
    rd_check("R1 alarm", 3'd5, 32'h0);
    rd_check("R1 key", 3'd7, 32'h0);
    check("R1 cal_hold", {31'b0, cal_hold}, 32'h0);
  endtask

  task automatic t_locked();
    wr(3'd2, 32'h1234);
    wr(3'd5, 32'hDEADBEEF);
    wr(3'd3, 32'h80);
    wr(3'd3, 32'h00);
    repeat (30) @(negedge clk);
    rd_check("R4 ctrl locked", 3'd2, 32'h0);
    rd_check("R4 alarm locked", 3'd5, 32'h0);
    rd_check("R4 stat locked", 3'd3, 32'h20);
    check("R4 cal_hold locked", {31'b0, cal_hold}, 32'h0);
  endtask

  task automatic t_unlock();
    wr(3'd7, 32'hCA);
    wr(3'd2, 32'h0999);   // not a key write, ignored while closed
    wr(3'd7, 32'h53);
    rd_check("R2 ctrl still old", 3'd2, 32'h0);
    wr(3'd2, 32'h0055);
    rd_check("R2 ctrl open", 3'd2, 32'h55);
    wr(3'd5, 32'hDEADBEEF);
    rd_check("R2 alarm open", 3'd5, 32'hDEADBEEF);
    check("R10 cal_ctrl", {16'b0, cal_ctrl}, 32'h55);
    check("R10 cal_alarm", cal_alarm, 32'hDEADBEEF);
  endtask

  task automatic t_relock();
    wr(3'd7, 32'hFF);
    wr(3'd2, 32'hAAAA);
    rd_check("R3 relock", 3'd2, 32'h55);
    wr(3'd7, 32'hCA);
    wr(3'd7, 32'h12);
    wr(3'd7, 32'h53);
    wr(3'd2, 32'h0077);
    rd_check("R3 wrong second key", 3'd2, 32'h55);
  endtask

  task automatic t_need_init();
    unlock();
    wr(3'd0, 32'h123456);
    wr(3'd1, 32'h250315);
    wr(3'd4, 32'h12);
    rd_check("R5 time w/o init", 3'd0, 32'h0);
    rd_check("R5 date w/o init", 3'd1, 32'h0);
    rd_check("R5 presc w/o init", 3'd4, 32'h7F00FF);
  endtask

  task automatic t_enter_init();
    logic [31:0] v;
    int used;
    wr(3'd3, 32'hA0);
    rd(3'd3, v);
    check("R6 ack not immediate", {31'b0, v[6]}, 32'h0);
    poll_stat(6, 1'b1, used);
    check("R6 ack arrives", {31'b0, (used <= 20)}, 32'h1);
    check("R6 cal_hold", {31'b0, cal_hold}, 32'h1);
    wr(3'd1, 32'h00000101);
    rd_check("R9 year zero", 3'd3, 32'hE0);
    wr(3'd1, 32'hFF250315);
    rd_check("R5 date masked", 3'd1, 32'h250315);
    rd_check("R9 year set", 3'd3, 32'hF0);
    wr(3'd0, 32'hFF123456);
    rd_check("R5 time masked", 3'd0, 32'h123456);
    wr(3'd4, 32'h00FF7FFF);
    rd_check("R5 presc masked", 3'd4, 32'h7F7FFF);
    check("R10 cal_time", {10'b0, cal_time}, 32'h123456);
    check("R10 cal_date", {8'b0, cal_date}, 32'h250315);
    check("R10 cal_presc", {9'b0, cal_presc}, 32'h7F7FFF);
  endtask

  task automatic t_exit_init();
    int used;
    wr(3'd3, 32'h20);
    poll_stat(6, 1'b0, used);
    check("R7 ack drops", {31'b0, (used <= 20)}, 32'h1);
    check("R7 cal_hold drops", {31'b0, cal_hold}, 32'h0);
    wr(3'd0, 32'h000111);
    rd_check("R7 time frozen", 3'd0, 32'h123456);
  endtask

  task automatic t_sync_flag();
    logic [31:0] v;
    int used;
    wr(3'd3, 32'h20);
    rd_check("R8 write one no effect", 3'd3, 32'h30);
    wr(3'd3, 32'h00);
    rd(3'd3, v);
    check("R8 flag cleared", {31'b0, v[5]}, 32'h0);
    poll_stat(5, 1'b1, used);
    check("R8 flag re-armed", {31'b0, (used <= 20)}, 32'h1);
    rd_check("R8 stat after", 3'd3, 32'h30);
    wr(3'd7, 32'hFF);
    wr(3'd3, 32'h80);
    wr(3'd3, 32'h00);
    repeat (30) @(negedge clk);
    rd_check("R4 stat locked again", 3'd3, 32'h30);
    check("R4 no hold when locked", {31'b0, cal_hold}, 32'h0);
  endtask

  initial begin
    repeat (20) @(negedge clk);
    rst = 1'b0;
    rtc_rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_locked();
    t_unlock();
    t_relock();
    t_need_init();
    t_enter_init();
    t_exit_init();
    t_sync_flag();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule